// File: doc/BRIEF.md
# Addressable Serial Bus Target Front End

This block lets one local function share a four-wire synchronous serial bus with many peers while using a single select line. The select line does not pick a device directly. While it is held low, the controller clocks an address byte into every target at once. When the select line goes high again, each target compares the byte it holds with its own address. The target that matches becomes the selected device. Every other target drops off the bus. Bytes that are clocked while the select line is high then go only to the selected device, and that device returns its own bytes on a data-out line that it drives only while selected.

All bus inputs are synchronised into the local clock domain, and both edges are detected there. The bus clock idles high, and both the controller and the target treat its rising edge as the bit boundary. The chained reset passes a reset to the next device with no clock delay. The downstream reset is released only after the controller has written this device an address with the configuration command (byte 0xA5 followed by the new address byte). The all-ones address is reserved as the "nobody" address that clears the bus.

Top module: `serial_addr_target`

## Requirements
- R1: While `bus_sel_n` is low, each rising edge of `bus_sck` shifts `bus_mosi` into an 8-bit address register, MSB first. Only the last 8 bits shifted before `bus_sel_n` rises count.
- R2: When `bus_sel_n` rises, the device becomes selected if the shifted address equals `dev_addr`, and becomes deselected otherwise. A selection persists over any number of data bytes, until `bus_sel_n` falls again.
- R3: `bus_miso_oe` is high only while the device is selected and `bus_sel_n` is high. It is low during every address phase and whenever the device is not selected.
- R4: Address 0xFF never matches, so sending 0xFF deselects the device. A configuration write whose address byte is 0xFF leaves `dev_addr` and `dev_configured` unchanged.
- R5: While the device is selected and `bus_sel_n` is high, `bus_mosi` bits are shifted MSB first on rising `bus_sck` edges. Every 8th bit produces a one-cycle `loc_rx_valid` pulse with the byte on `loc_rx_data`. A device that is not selected produces no pulse.
- R6: `rst_out_n` goes low in the same instant as `rst_in_n` goes low, with no clock involved. It stays low after `rst_in_n` is released, until the device is configured.
- R7: Byte 0xA5 followed by an address byte, both received while selected, loads `dev_addr` with the address byte, sets `dev_configured` and releases `rst_out_n`. Neither byte is delivered on `loc_rx_valid`.
- R8: `loc_tx_data` is captured when the device becomes selected and again after each 8th data bit, with a `loc_tx_ack` pulse at each capture. It is presented on `bus_miso` MSB first, and the next bit appears after each rising `bus_sck` edge.
- R9: After reset, `dev_addr` is 0x00, the device is not selected, `dev_configured` is low and `bus_miso_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_in_n | input | 1 | Chained reset from upstream, active low, asynchronous |
| bus_sck | input | 1 | Bus clock, idles high |
| bus_sel_n | input | 1 | Shared select; low = address phase |
| bus_mosi | input | 1 | Controller-to-target data |
| bus_miso | output | 1 | Target-to-controller data value |
| bus_miso_oe | output | 1 | Output enable for the `bus_miso` driver |
| rst_out_n | output | 1 | Chained reset to downstream device, active low |
| loc_rx_data | output | 8 | Received data byte |
| loc_rx_valid | output | 1 | One-cycle strobe for `loc_rx_data` |
| loc_tx_data | input | 8 | Byte to return to the controller |
| loc_tx_ack | output | 1 | One-cycle strobe when `loc_tx_data` is captured |
| dev_addr | output | 8 | Current device address |
| dev_configured | output | 1 | Device has received its configuration |

## Verification
The bench sends an address that is 12 bits long, so a target that kept the first 8 bits, instead of the last 8, would miss its own address. It sends data to a device that was left unselected. A target that did not gate its receive path would then deliver bytes it does not own, and one that ignored the address phase would drive `bus_miso` while another device holds the bus. It sends 0xFF both as an address and as a configuration payload, which exposes a target that matches the reserved value or that accepts it as its new address. It changes `loc_tx_data` between two bytes and pulls `rst_in_n` low after configuration. These steps catch a stale transmit reload, and a reset chain that waits for a clock or releases too early.

// File: rtl/serial_addr_target_pkg.sv
package serial_addr_target_pkg;
  parameter int AW = 8;
  typedef logic [AW-1:0] addr_t;
  localparam addr_t NOBODY = '1;

  // A shifted address selects this device only when it is equal and not reserved.
  function automatic logic addr_hit(input addr_t shifted, input addr_t own);
    return (shifted == own) && (shifted != NOBODY);
  endfunction

  // Shift one serial bit in at the LSB, with the MSB arriving first.
  function automatic addr_t shift_in(input addr_t cur, input logic b);
    return {cur[AW-2:0], b};
  endfunction
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/addr_stage.sv
module addr_stage
  import serial_addr_target_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sck_rise,
  input  logic  sel_low,
  input  logic  sel_open,
  input  logic  sel_close,
  input  logic  mosi,
  input  addr_t own_addr,
  output logic  selected,
  output logic  select_pulse
);
  addr_t shift_q;

  assign select_pulse = sel_close && addr_hit(shift_q, own_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q  <= '0;
      selected <= 1'b0;
    end else begin
      if (sel_open) selected <= 1'b0;
      if (sck_rise && sel_low) shift_q <= shift_in(shift_q, mosi);
      if (sel_close) selected <= select_pulse;
    end
  end

  a_r1_addr_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && sel_low) |=> (shift_q[0] == $past(mosi)));
  a_r2_drop_on_open: assert property (@(posedge clk) disable iff (!rst_n)
    sel_open |=> !selected);
  a_r4_nobody: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_close && shift_q == NOBODY) |=> !selected);
endmodule

// File: rtl/data_stage.sv
module data_stage
  import serial_addr_target_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] CFG_CMD = 8'hA5,
  parameter addr_t RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_rise,
  input  logic          active,
  input  logic          load_start,
  input  logic          mosi,
  input  logic [DW-1:0] tx_data,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          tx_ack,
  output logic          miso_bit,
  output addr_t         dev_addr,
  output logic          configured
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [DW-1:0] rx_sh, tx_sh;
  logic [CW-1:0] cnt;
  logic          cfg_pend;
  logic [DW-1:0] byte_now;
  logic          bit_step, byte_end;

  assign bit_step = sck_rise && active;
  assign byte_end = bit_step && (cnt == LAST);
  assign byte_now = {rx_sh[DW-2:0], mosi};
  assign miso_bit = tx_sh[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh <= '0; tx_sh <= '0; cnt <= '0; cfg_pend <= 1'b0;
      rx_data <= '0; rx_valid <= 1'b0; tx_ack <= 1'b0;
      dev_addr <= RESET_ADDR; configured <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_ack   <= 1'b0;
      if (load_start) begin
        cnt <= '0; tx_sh <= tx_data; tx_ack <= 1'b1; cfg_pend <= 1'b0;
      end else if (bit_step) begin
        rx_sh <= byte_now;
        tx_sh <= {tx_sh[DW-2:0], 1'b0};
        cnt   <= cnt + 1'b1;
        if (byte_end) begin
          cnt    <= '0;
          tx_sh  <= tx_data;
          tx_ack <= 1'b1;
          if (cfg_pend) begin
            cfg_pend <= 1'b0;
            if (byte_now[AW-1:0] != NOBODY) begin
              dev_addr   <= byte_now[AW-1:0];
              configured <= 1'b1;
            end
          end else if (byte_now == CFG_CMD) begin
            cfg_pend <= 1'b1;
          end else begin
            rx_data  <= byte_now;
            rx_valid <= 1'b1;
          end
        end
      end
    end
  end

  a_r5_rx_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(active));
  a_r7_cfg_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(configured) |-> $past(cfg_pend));
  a_r8_tx_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_step && !byte_end && !load_start) |=> (miso_bit == $past(tx_sh[DW-2])));
endmodule

// File: rtl/serial_addr_target.sv
module serial_addr_target
  import serial_addr_target_pkg::*;
#(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_in_n,
  input  logic          bus_sck,
  input  logic          bus_sel_n,
  input  logic          bus_mosi,
  output logic          bus_miso,
  output logic          bus_miso_oe,
  output logic          rst_out_n,
  output logic [DW-1:0] loc_rx_data,
  output logic          loc_rx_valid,
  input  logic [DW-1:0] loc_tx_data,
  output logic          loc_tx_ack,
  output addr_t         dev_addr,
  output logic          dev_configured
);
  logic [2:0] sync_q;
  logic sck_s, sel_n_s, mosi_s, sck_d, sel_n_d;
  logic sck_rise, sel_open, sel_close;
  logic selected, select_pulse, active, miso_bit;

  bus_sync #(.N(3), .STAGES(SYNC_STAGES), .INIT(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_in_n),
    .din({bus_sck, bus_sel_n, bus_mosi}), .q(sync_q));

  assign {sck_s, sel_n_s, mosi_s} = sync_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      sck_d <= 1'b1; sel_n_d <= 1'b1;
    end else begin
      sck_d <= sck_s; sel_n_d <= sel_n_s;
    end
  end

  assign sck_rise  = sck_s & ~sck_d;
  assign sel_open  = sel_n_d & ~sel_n_s;
  assign sel_close = ~sel_n_d & sel_n_s;

  addr_stage u_addr (
    .clk(clk), .rst_n(rst_in_n), .sck_rise(sck_rise), .sel_low(~sel_n_s),
    .sel_open(sel_open), .sel_close(sel_close), .mosi(mosi_s),
    .own_addr(dev_addr), .selected(selected), .select_pulse(select_pulse));

  assign active = selected & sel_n_s;

  data_stage #(.DW(DW)) u_data (
    .clk(clk), .rst_n(rst_in_n), .sck_rise(sck_rise), .active(active),
    .load_start(select_pulse), .mosi(mosi_s), .tx_data(loc_tx_data),
    .rx_data(loc_rx_data), .rx_valid(loc_rx_valid), .tx_ack(loc_tx_ack),
    .miso_bit(miso_bit), .dev_addr(dev_addr), .configured(dev_configured));

  assign bus_miso_oe = active;
  assign bus_miso    = active ? miso_bit : 1'b0;
  assign rst_out_n   = rst_in_n & dev_configured;

  a_r3_quiet_in_addr_phase: assert property (@(posedge clk) disable iff (!rst_in_n)
    sel_open |=> !bus_miso_oe);
  a_r6_hold_until_cfg: assert property (@(posedge clk) disable iff (!rst_in_n)
    !dev_configured |-> !rst_out_n);
endmodule

// File: tb/serial_addr_target_tb_top.sv
module serial_addr_target_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_in_n = 1'b0, sck = 1'b1, sel_n = 1'b1, mosi = 1'b0;
  logic [7:0] tx = 8'h3C;
  logic miso, miso_oe, rst_out_n, rx_valid, tx_ack, configured;
  logic [7:0] rx_data, dev_addr;

  serial_addr_target dut_i (
    .clk(clk), .rst_in_n(rst_in_n), .bus_sck(sck), .bus_sel_n(sel_n),
    .bus_mosi(mosi), .bus_miso(miso), .bus_miso_oe(miso_oe),
    .rst_out_n(rst_out_n), .loc_rx_data(rx_data), .loc_rx_valid(rx_valid),
    .loc_tx_data(tx), .loc_tx_ack(tx_ack), .dev_addr(dev_addr),
    .dev_configured(configured));

  int checks = 0, fails = 0, rx_n = 0, cycles = 0;
  logic [7:0] rx_log [16];

  always @(posedge clk) begin
    if (rx_valid) begin
      if (rx_n < 16) rx_log[rx_n] <= rx_data;
      rx_n <= rx_n + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One bus bit: present data, low phase, sample returned bit, rising edge.
  task automatic bus_bit(input logic b, output logic got);
    mosi = b; sck = 1'b0; wait_n(8);
    got = miso; sck = 1'b1; wait_n(8);
  endtask

  task automatic send_addr(input logic [15:0] val, input int nbits);
    logic g;
    sel_n = 1'b0; wait_n(8);
    check("R3 oe low in address phase", miso_oe, 1'b0);
    for (int i = nbits - 1; i >= 0; i--) bus_bit(val[i], g);
    sel_n = 1'b1; wait_n(8);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic [7:0] exp_tx, input logic chk);
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], got[i]);
    if (chk) check("R8 miso byte", got, exp_tx);
  endtask

  task automatic t_reset;
    check("R6 rst_out low in reset", rst_out_n, 1'b0);
    rst_in_n = 1'b1; wait_n(4);
    check("R9 addr default", dev_addr, 8'h00);
    check("R9 not configured", configured, 1'b0);
    check("R9 oe low", miso_oe, 1'b0);
    check("R6 rst_out held after release", rst_out_n, 1'b0);
  endtask

  task automatic t_configure;
    send_addr(16'h0000, 8);
    check("R2 default address selects", miso_oe, 1'b1);
    send_byte(8'hA5, 8'h3C, 1'b1);
    send_byte(8'h5A, 8'h3C, 1'b1);
    check("R7 address loaded", dev_addr, 8'h5A);
    check("R7 configured", configured, 1'b1);
    check("R7 rst_out released", rst_out_n, 1'b1);
    check("R7 config bytes not delivered", rx_n, 0);
  endtask

  task automatic t_data_rx;
    send_byte(8'hC3, 8'h3C, 1'b1);
    check("R5 one byte received", rx_n, 1);
    check("R5 byte value", rx_log[0], 8'hC3);
    check("R2 selection persists", miso_oe, 1'b1);
  endtask

  task automatic t_other_device;
    send_addr(16'h0011, 8);
    check("R2 mismatch deselects", miso_oe, 1'b0);
    send_byte(8'h77, 8'h00, 1'b0);
    check("R5 unselected ignores data", rx_n, 1);
    check("R3 no drive while unselected", miso_oe, 1'b0);
  endtask

  task automatic t_long_addr_and_tx;
    tx = 8'hE1;
    send_addr(16'h0A5A, 12);
    check("R1 last 8 bits select", miso_oe, 1'b1);
    tx = 8'h0F;
    send_byte(8'h96, 8'hE1, 1'b1);
    send_byte(8'h01, 8'h0F, 1'b1);
    check("R5 two more bytes", rx_n, 3);
    check("R5 byte 2", rx_log[1], 8'h96);
    check("R5 byte 3", rx_log[2], 8'h01);
  endtask

  task automatic t_nobody;
    send_byte(8'hA5, 8'h0F, 1'b0);
    send_byte(8'hFF, 8'h0F, 1'b0);
    check("R4 ff config ignored", dev_addr, 8'h5A);
    check("R4 ff config still configured", configured, 1'b1);
    send_addr(16'h00FF, 8);
    check("R4 nobody deselects", miso_oe, 1'b0);
    send_addr(16'h005A, 8);
    check("R2 reselect", miso_oe, 1'b1);
  endtask

  task automatic t_rechain;
    rst_in_n = 1'b0; #1;
    check("R6 rst_out follows at once", rst_out_n, 1'b0);
    wait_n(3);
    rst_in_n = 1'b1; wait_n(4);
    check("R6 held after second reset", rst_out_n, 1'b0);
    check("R9 addr restored", dev_addr, 8'h00);
    check("R9 oe low after reset", miso_oe, 1'b0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    wait_n(5);
    t_reset();
    t_configure();
    t_data_rx();
    t_other_device();
    t_long_addr_and_tx();
    t_nobody();
    t_rechain();
    finish_run();
  end
endmodule